// File: doc/BRIEF.md
# Infrared Run-Length Pulse Transmitter

This block drives an infrared emitter from a queue of run-length coded bytes. A host writes bytes into a 32-entry transmit queue. Each byte names a polarity and a run length. The block replays the bytes one after another. A mark turns the carrier on and a space turns it off. Each run lasts a whole number of sample periods, and a sample period is marked by a one-cycle `tick` enable. During a mark, a carrier generator set by two plain configuration inputs gates the single drive output.

The host watches `used_cnt` and the `low_level` flag, which is raised by a coded low-water threshold. When the flag rises, the host tops the queue up so that a long burst plays without gaps. A single clear input flushes the queue and stops the run in progress. A write that meets a full queue is lost and is recorded in a sticky error bit.

Top module: `irtx_pulse_engine`

## Requirements
- R1: While reset is held and just after it is released, `used_cnt` is 0, `low_level` is 1, `wr_overflow` is 0 and `ir_out` is 0.
- R2: The engine is idle whenever it has no run loaded. An idle engine takes the oldest queued byte on the clock edge after the queue becomes non-empty. An accepted write raises `used_cnt` by one, and each byte the engine takes lowers it by one.
- R3: Bit 7 of a byte selects the run type: 0 gives a mark and 1 gives a space. `ir_out` stays 0 for the whole of a space.
- R4: Bits 6:0 hold a value n, and the run lasts n+1 sample ticks. A value of 0 gives one tick and a value of 127 gives 128 ticks.
- R5: Queued bytes play back to back with no gap. Consecutive bytes of the same type join into one run whose length is the sum of their durations.
- R6: When the queue is empty and the current run ends, the output falls to the space level and stays there.
- R7: `thr_sel` picks the low-water level: 0 gives 1 entry, 1 gives 7, 2 gives 17 and 3 gives 25. Code 2 is the value the host should drive after reset. `low_level` is 1 exactly when `used_cnt` is at or below that level.
- R8: The queue holds 32 bytes. A write that arrives when the queue is full is dropped, and it sets `wr_overflow`. That bit stays set until a clear.
- R9: `fifo_clr` empties the queue on the next edge, ends the current run and clears `wr_overflow`. A write in the same cycle as a clear is discarded.
- R10: During a mark, the carrier period is 4 + `car_code` clock cycles. The high time is min(`pw_code`+1, period-1) cycles. The carrier restarts high on the first cycle of a mark that follows a space or idle.
- R11: A run advances only on cycles where `tick` is 1. With `tick` held low, the current run and its carrier continue without end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per sample period |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Run byte: bit 7 space, bits 6:0 length-1 |
| fifo_clr | input | 1 | Flush queue and stop playback |
| thr_sel | input | 2 | Low-water level code |
| car_code | input | 5 | Carrier period code |
| pw_code | input | 3 | Carrier high-time code |
| used_cnt | output | 6 | Number of queued bytes |
| low_level | output | 1 | Queue at or below low-water level |
| wr_overflow | output | 1 | Sticky write-to-full error |
| ir_out | output | 1 | Modulated emitter drive |

## Verification
The bench plays every run length from 0 to 127. It alternates polarity so that each run boundary shows in the output. A design off by one in the length decode would shift every later boundary by one tick. A design that mishandles the zero length would drop or stretch the one-tick runs.

For each threshold code, the bench walks the queue from empty to full and compares the flag at every fill level. An inverted comparison or a wrong level table would change the flag one entry early or late.

The bench writes once more into a full queue. A design that wraps its pointers there would corrupt the data or the count, and a design without the sticky bit would miss the error. The bench also issues a clear together with a write, and checks that no stale byte survives.

The bench sweeps all 256 carrier settings. A wrong period or a missing clamp would change the number of rising edges or high cycles measured in a window of two periods.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  // One queued run: polarity flag over a length-minus-one field.
  typedef struct packed {
    logic       space;
    logic [6:0] len;
  } irtx_sym_t;

  // Low-water level selected by the 2-bit threshold code.
  function automatic int unsigned low_mark(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 7;
      2'd2:    return 17;
      default: return 25;
    endcase
  endfunction

endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             accept, take;

  always_comb begin
    accept = push && (cnt_q != FULL) && !clr;
    take   = pop && (cnt_q != '0) && !clr;
    wp_d   = wp_q;
    rp_d   = rp_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (accept) wp_d = (wp_q == LAST) ? '0 : wp_q + AW'(1);
      if (take)   rp_d = (rp_q == LAST) ? '0 : rp_q + AW'(1);
      if (accept && !take)      cnt_d = cnt_q + CNT_W'(1);
      else if (take && !accept) cnt_d = cnt_q - CNT_W'(1);
      if (push && (cnt_q == FULL)) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign ovf   = ovf_q;
endmodule

// File: rtl/irtx_seq.sv
module irtx_seq #(
  parameter int LEN_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           tick,
  input  logic           empty,
  input  logic [LEN_W:0] rdata,
  output logic           pop,
  output logic           mark
);
  localparam int RW = LEN_W + 1;

  logic          act_q, act_d;
  logic          spc_q, spc_d;
  logic [RW-1:0] rem_q, rem_d;
  logic          ending;

  always_comb begin
    act_d  = act_q;
    spc_d  = spc_q;
    rem_d  = rem_q;
    pop    = 1'b0;
    ending = !act_q || (tick && (rem_q == RW'(1)));
    if (clr) begin
      act_d = 1'b0;
    end else if (ending) begin
      if (!empty) begin
        pop   = 1'b1;
        act_d = 1'b1;
        spc_d = rdata[LEN_W];
        rem_d = {1'b0, rdata[LEN_W-1:0]} + RW'(1);
      end else begin
        act_d = 1'b0;
      end
    end else if (tick) begin
      rem_d = rem_q - RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      spc_q <= 1'b1;
      rem_q <= '0;
    end else begin
      act_q <= act_d;
      spc_q <= spc_d;
      rem_q <= rem_d;
    end
  end

  assign mark = act_q && !spc_q;
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int CODE_W = 5,
  parameter int PW_W   = 3,
  parameter int BASE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark,
  input  logic [CODE_W-1:0] code,
  input  logic [PW_W-1:0]   pw,
  output logic              drive
);
  localparam int PER_W = $clog2(BASE + (1 << CODE_W));

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] period, hi_raw, hi;

  always_comb begin
    period = PER_W'(BASE) + PER_W'(code);
    hi_raw = PER_W'(pw) + PER_W'(1);
    hi     = (hi_raw < period) ? hi_raw : period - PER_W'(1);
    if (!mark)                            cnt_d = '0;
    else if (cnt_q >= period - PER_W'(1)) cnt_d = '0;
    else                                  cnt_d = cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign drive = mark && (cnt_q < hi);
endmodule

// File: rtl/irtx_pulse_engine.sv
module irtx_pulse_engine #(
  parameter  int DEPTH    = 32,
  parameter  int CAR_BASE = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             fifo_clr,
  input  logic [1:0]       thr_sel,
  input  logic [4:0]       car_code,
  input  logic [2:0]       pw_code,
  output logic [CNT_W-1:0] used_cnt,
  output logic             low_level,
  output logic             wr_overflow,
  output logic             ir_out
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       pop_w, empty_w, mark_w;
  logic [7:0] head_w;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  irtx_fifo #(.DEPTH(DEPTH), .DW(8), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n_s), .clr(fifo_clr), .push(wr_en),
    .wdata(wr_data), .pop(pop_w), .rdata(head_w), .count(used_cnt),
    .empty(empty_w), .ovf(wr_overflow)
  );

  irtx_seq #(.LEN_W(7)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .clr(fifo_clr), .tick(tick),
    .empty(empty_w), .rdata(head_w), .pop(pop_w), .mark(mark_w)
  );

  irtx_carrier #(.CODE_W(5), .PW_W(3), .BASE(CAR_BASE)) u_car (
    .clk(clk), .rst_n(rst_n_s), .mark(mark_w), .code(car_code),
    .pw(pw_code), .drive(ir_out)
  );

  assign low_level = (32'(used_cnt) <= irtx_pkg::low_mark(thr_sel));
endmodule

// File: rtl/irtx_pulse_engine_chk.sv
module irtx_pulse_engine_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             fifo_clr,
  input logic [CNT_W-1:0] used_cnt,
  input logic             low_level,
  input logic             wr_overflow,
  input logic             ir_out,
  input logic             mark
);
  assert_used_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(used_cnt) <= DEPTH);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_overflow && !fifo_clr) |=> wr_overflow);

  assert_clr_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (used_cnt == '0 && !ir_out && !wr_overflow));

  assert_low_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (used_cnt == '0) |-> low_level);

  assert_high_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(used_cnt) == DEPTH) |-> !low_level);

  assert_mod_in_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ir_out |-> mark);

  assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && !tick && !fifo_clr) |=> mark);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_clr |=> (32'(used_cnt) <= 32'($past(used_cnt)) + 1));
endmodule

bind irtx_pulse_engine irtx_pulse_engine_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_clr(fifo_clr),
  .used_cnt(used_cnt), .low_level(low_level), .wr_overflow(wr_overflow),
  .ir_out(ir_out), .mark(mark_w)
);

// File: tb/sim_irtx_pulse_engine.sv
module sim_irtx_pulse_engine;
  logic       clk = 1'b0;
  logic       rst_n, tick, wr_en, fifo_clr;
  logic [7:0] wr_data;
  logic [1:0] thr_sel;
  logic [4:0] car_code;
  logic [2:0] pw_code;
  logic [5:0] used_cnt;
  logic       low_level, wr_overflow, ir_out;

  int checks = 0;
  int failures = 0;
  logic [7:0] bytes [0:32];

  localparam int WIN = 6;

  always #2 clk = ~clk;

  irtx_pulse_engine u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_clr(fifo_clr), .thr_sel(thr_sel), .car_code(car_code),
    .pw_code(pw_code), .used_cnt(used_cnt), .low_level(low_level),
    .wr_overflow(wr_overflow), .ir_out(ir_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic flush();
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic observe(output bit seen, output bit first);
    first = ir_out;
    seen  = ir_out;
    for (int c = 1; c < WIN; c++) begin
      @(negedge clk);
      seen = seen | ir_out;
    end
  endtask

  // Play bytes[0..n-1] and compare the envelope window by window.
  task automatic run_batch(input int n, input string tag);
    bit seen, first;
    flush();
    for (int i = 0; i < n; i++) put(bytes[i]);
    @(negedge clk); @(negedge clk);
    check(32'(used_cnt) == n - 1, "R2 used after load", int'(used_cnt), n - 1);
    for (int j = 0; j < n; j++) begin
      for (int k = 0; k <= int'(bytes[j][6:0]); k++) begin
        observe(seen, first);
        check(seen == !bytes[j][7], tag, int'(seen), int'(!bytes[j][7]));
        if (k == 0 && j > 0 && !bytes[j][7] && bytes[j-1][7])
          check(first == 1'b1, "R10 carrier restart", int'(first), 1);
        pulse();
      end
    end
    for (int e = 0; e < 2; e++) begin
      observe(seen, first);
      check(seen == 1'b0, "R6 drained to space", int'(seen), 0);
      pulse();
    end
    check(used_cnt == 6'd0, "R6 queue empty", int'(used_cnt), 0);
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit seen, first;
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; fifo_clr = 1'b0;
    wr_data = 8'h00; thr_sel = 2'd2; car_code = 5'd0; pw_code = 3'd4;
    repeat (3) @(negedge clk);
    check(used_cnt == 0 && low_level && !wr_overflow && !ir_out,
          "R1 in reset", {used_cnt, low_level, wr_overflow, ir_out}, 9'b000000100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(used_cnt == 0 && low_level && !wr_overflow && !ir_out,
          "R1 after release", {used_cnt, low_level, wr_overflow, ir_out}, 9'b000000100);

    // R3/R4: every length, alternating polarity, in batches of 32.
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 32; i++)
        bytes[i] = {1'(i % 2), 7'(b * 32 + i)};
      run_batch(32, "R3 R4 length sweep");
    end

    // R5: same-polarity bytes join.
    bytes[0] = 8'h02; bytes[1] = 8'h03; bytes[2] = 8'h80; bytes[3] = 8'h84;
    bytes[4] = 8'h00;
    run_batch(5, "R5 joined runs");

    // R7/R8/R9: thresholds over every fill level, then overflow and clear.
    for (int s = 0; s < 4; s++) begin
      int lvl;
      lvl = (s == 0) ? 1 : (s == 1) ? 7 : (s == 2) ? 17 : 25;
      thr_sel = 2'(s);
      flush();
      check(low_level == 1'b1, "R7 empty flag", int'(low_level), 1);
      put(8'h7F);
      @(negedge clk);
      for (int i = 1; i <= 32; i++) begin
        put(8'h05);
        check(32'(used_cnt) == i, "R2 fill count", int'(used_cnt), i);
        check(low_level == (i <= lvl), "R7 low flag", int'(low_level), int'(i <= lvl));
      end
      check(!wr_overflow, "R8 no error at full", int'(wr_overflow), 0);
      put(8'h11);
      check(wr_overflow && used_cnt == 6'd32, "R8 write to full",
            {used_cnt, wr_overflow}, {6'd32, 1'b1});
      // R11: no ticks, the mark keeps running.
      seen = 1'b0;
      repeat (100) begin @(negedge clk); seen = seen | ir_out; end
      check(seen && wr_overflow, "R11 hold without tick", int'(seen), 1);
      fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 8'h01;
      @(negedge clk);
      fifo_clr = 1'b0; wr_en = 1'b0;
      check(used_cnt == 0 && !wr_overflow && !ir_out, "R9 clear with write",
            {used_cnt, wr_overflow, ir_out}, 0);
      repeat (3) @(negedge clk);
      check(used_cnt == 0 && !ir_out, "R9 stays empty", {used_cnt, ir_out}, 0);
    end
    thr_sel = 2'd2;

    // R10: every carrier setting over a long mark.
    flush();
    put(8'h7F);
    for (int c = 0; c < 32; c++) begin
      for (int p = 0; p < 8; p++) begin
        int per, hi, highs, rises;
        logic prev;
        car_code = 5'(c); pw_code = 3'(p);
        per = 4 + c;
        hi = (p + 1 < per) ? p + 1 : per - 1;
        repeat (40) @(negedge clk);
        highs = 0; rises = 0; prev = ir_out;
        if (ir_out) highs++;
        for (int t = 1; t <= 2 * per; t++) begin
          @(negedge clk);
          if (t < per && ir_out) highs++;
          if (!prev && ir_out) rises++;
          prev = ir_out;
        end
        check(highs == hi, "R10 high time", highs, hi);
        check(rises == 2, "R10 period", rises, 2);
      end
    end
    car_code = 5'd0; pw_code = 3'd4;
    flush();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule